// File: doc/BRIEF.md
# Input Clock Loss Monitor

This block watches one or more input clocks, each of unknown frequency, using a free-running reference clock. For every input it drives a status flag. The flag is high while the input is judged absent and low while the input is toggling. Each input has its own monitor and its own flag, and what happens on one input never disturbs another.

The two directions of the flag have very different timing. A stopped clock is reported only after a long run of reference cycles with no observed edge. That run is set by a parameter, and its default is about 15 µs at a 125 MHz reference. A returning clock is reported within a few reference cycles of its first edge. Recovery can also be made to wait for several edges in a row. Such edges count as one run as long as no full idle interval falls between them.

In each input's domain, every rising edge flips a flop. That flop value crosses into the reference domain through a flop synchronizer. Any change in the synchronized value is counted as activity. The input clocks are taken to run during reset, so that their edge flops start from zero.

Top module: `clkmon_los`

## Requirements
- R1: After reset every flag reads 1 (absent). It stays 1 for as long as its input produces no rising edge.
- R2: With an input clock of 20 ns period running, its flag reads 0 within 8 reference cycles of the clock starting, and it stays 0.
- R3: With one edge needed for recovery, a single rising edge on an absent input brings the flag to 0. The flag is still 1 one reference cycle after the edge and is 0 by SYNC_STAGES+4 reference cycles after it.
- R4: After the last rising edge of an input, its flag is still 0 at ACT_CYCLES-2 reference cycles and reads 1 by ACT_CYCLES+8 reference cycles.
- R5: Stopping one input sets only that input's flag. A running input keeps its flag at 0.
- R6: With CLR_EDGES=3, one or two edges on an absent input leave the flag at 1. A third edge, with each gap between edges well under ACT_CYCLES reference cycles, clears it.
- R7: When an absent input sees a gap of more than ACT_CYCLES reference cycles with no edge, the edges counted toward recovery so far are discarded.
- R8: An input whose period is 20 reference cycles, which is slower than the reference clock but faster than the idle interval, keeps its flag at 0 in every reference cycle.
- R9: An input near 725 MHz, far faster than the reference clock, is reported present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset, also sampled in each input domain |
| clk_mon | input | NUM_INPUTS | Monitored clocks, one bit per input |
| los | output | NUM_INPUTS | Per-input flag: 1 = absent, 0 = present |

## Verification
The hardest state to reach from the ports is an absent input partway through a multi-edge recovery, with an idle gap then landing in the middle of that recovery. The bench does not use a free-running generator here. It drives the monitored pin one pulse at a time. It places two pulses, then holds the pin still for longer than the idle interval, then pulses again. This shows whether the earlier edges were forgotten. Aliasing is also hard to provoke: the bench uses a 725 MHz input and a slow input whose period is many reference cycles, to probe both ends of the range.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    // Monitor state; the encoding equals the flag value driven out.
    typedef enum logic {
        MON_PRESENT = 1'b0,
        MON_ABSENT  = 1'b1
    } mon_state_e;

    // Width needed to hold values 0..n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/clkmon_edge_toggle.sv
module clkmon_edge_toggle (
    input  logic clk_mon,
    input  logic rst,
    output logic tgl
);
    // Flips once per rising edge of the monitored clock.
    always_ff @(posedge clk_mon) begin
        if (rst) tgl <= 1'b0;
        else     tgl <= ~tgl;
    end
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic tgl_async,
    output logic activity
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_ref) begin
                if (rst) sync_q <= '0;
                else     sync_q <= tgl_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk_ref) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], tgl_async};
            end
        end
    endgenerate

    always_ff @(posedge clk_ref) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign activity = sync_q[STAGES-1] ^ prev_q;

    // Right after reset no stale change may be reported.
    assert_sync_quiet_after_reset_R1: assert property (
        @(posedge clk_ref) $past(rst) |-> !activity);

endmodule

// File: rtl/clkmon_los_fsm.sv
module clkmon_los_fsm
    import clkmon_pkg::*;
#(
    parameter int unsigned ACT_CYCLES = 1875,
    parameter int unsigned CLR_EDGES  = 1
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic activity,
    output logic los
);
    localparam int unsigned IW = cnt_width(ACT_CYCLES);
    localparam int unsigned EW = cnt_width(CLR_EDGES);
    localparam logic [IW-1:0] IDLE_LIM = IW'(ACT_CYCLES);
    localparam logic [EW-1:0] EDGE_LIM = EW'(CLR_EDGES);

    mon_state_e    state_q, state_n;
    logic [IW-1:0] idle_q, idle_n;
    logic [EW-1:0] edges_q, edges_n;
    logic          idle_full;

    always_comb begin
        if (activity)              idle_n = '0;
        else if (idle_q != IDLE_LIM) idle_n = idle_q + 1'b1;
        else                       idle_n = idle_q;
        idle_full = (idle_n == IDLE_LIM);

        state_n = state_q;
        edges_n = '0;
        unique case (state_q)
            MON_PRESENT: begin
                if (idle_full) state_n = MON_ABSENT;
            end
            MON_ABSENT: begin
                if (activity) begin
                    if (edges_q + 1'b1 == EDGE_LIM) begin
                        state_n = MON_PRESENT;
                        edges_n = '0;
                    end else begin
                        edges_n = edges_q + 1'b1;
                    end
                end else if (idle_full) begin
                    edges_n = '0;
                end else begin
                    edges_n = edges_q;
                end
            end
            default: state_n = MON_ABSENT;
        endcase
    end

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            state_q <= MON_ABSENT;
            idle_q  <= '0;
            edges_q <= '0;
        end else begin
            state_q <= state_n;
            idle_q  <= idle_n;
            edges_q <= edges_n;
        end
    end

    assign los = (state_q == MON_ABSENT);

    // Recovery only follows observed activity.
    assert_clear_needs_activity_R3: assert property (
        @(posedge clk_ref) disable iff (rst) $fell(los) |-> $past(activity));

    // Loss is never declared in a cycle that saw activity.
    assert_loss_needs_idle_R4: assert property (
        @(posedge clk_ref) disable iff (rst) $rose(los) |-> !$past(activity));

    // Activity while present keeps the flag low next cycle.
    assert_activity_holds_present_R2: assert property (
        @(posedge clk_ref) disable iff (rst) (activity && !los) |=> !los);

    // The recovery counter never passes its target.
    assert_edge_count_bound_R6: assert property (
        @(posedge clk_ref) disable iff (rst) edges_q < EDGE_LIM);

endmodule

// File: rtl/clkmon_los.sv
module clkmon_los #(
    parameter int unsigned NUM_INPUTS  = 2,
    parameter int unsigned ACT_CYCLES  = 1875,
    parameter int unsigned CLR_EDGES   = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_ref,
    input  logic                  rst,
    input  logic [NUM_INPUTS-1:0] clk_mon,
    output logic [NUM_INPUTS-1:0] los
);
    logic [NUM_INPUTS-1:0] tgl;
    logic [NUM_INPUTS-1:0] act;

    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_ch
            clkmon_edge_toggle u_tgl (
                .clk_mon (clk_mon[i]),
                .rst     (rst),
                .tgl     (tgl[i])
            );
            clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk_ref   (clk_ref),
                .rst       (rst),
                .tgl_async (tgl[i]),
                .activity  (act[i])
            );
            clkmon_los_fsm #(
                .ACT_CYCLES (ACT_CYCLES),
                .CLR_EDGES  (CLR_EDGES)
            ) u_fsm (
                .clk_ref  (clk_ref),
                .rst      (rst),
                .activity (act[i]),
                .los      (los[i])
            );
        end
    endgenerate

    // Every flag starts at absent.
    assert_reset_all_absent_R1: assert property (
        @(posedge clk_ref) $past(rst) |-> (&los));

endmodule

// File: tb/clkmon_los_bench.sv
`timescale 1ns/1ps
module clkmon_los_bench;
    localparam int ACT = 64;
    localparam int SYN = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] gen = 2'b00;
    logic [1:0] pa  = 2'b00;
    logic       pb  = 1'b0;
    logic [1:0] run = 2'b00;
    realtime    half0 = 10.0, half1 = 10.0;
    logic [1:0] los_a, los_b;
    logic [1:0] mon_a, mon_b;
    int n_chk = 0, n_fail = 0;

    assign mon_a = gen | pa;
    assign mon_b = {1'b0, pb};

    always #4 clk = ~clk;

    always begin
        if (run[0]) begin #(half0); gen[0] = ~gen[0]; end
        else begin gen[0] = 1'b0; wait (run[0]); end
    end
    always begin
        if (run[1]) begin #(half1); gen[1] = ~gen[1]; end
        else begin gen[1] = 1'b0; wait (run[1]); end
    end

    clkmon_los #(.NUM_INPUTS(2), .ACT_CYCLES(ACT), .CLR_EDGES(1), .SYNC_STAGES(SYN))
        u_clkmon_los (.clk_ref(clk), .rst(rst), .clk_mon(mon_a), .los(los_a));
    clkmon_los #(.NUM_INPUTS(2), .ACT_CYCLES(ACT), .CLR_EDGES(3), .SYNC_STAGES(SYN))
        u_clkmon_los_clr3 (.clk_ref(clk), .rst(rst), .clk_mon(mon_b), .los(los_b));

    task automatic wait_ref(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic pulse_a0();
        pa[0] = 1'b1; #3; pa[0] = 1'b0; #3;
    endtask
    task automatic pulse_b();
        pb = 1'b1; #3; pb = 1'b0; #3;
    endtask

    task automatic test_reset_R1();
        pa = 2'b11; pb = 1'b1; #3; pa = 2'b00; pb = 1'b0;
        wait_ref(4);
        rst = 1'b0;
        wait_ref(1);
        chk("R1 los_a after reset", los_a, 3);
        chk("R1 los_b after reset", los_b, 3);
        wait_ref(ACT + 10);
        chk("R1 los_a idle", los_a, 3);
        chk("R1 los_b idle", los_b, 3);
    endtask

    task automatic test_single_edge_R3();
        pulse_a0();
        wait_ref(1);
        chk("R3 flag not yet clear", los_a[0], 1);
        wait_ref(SYN + 3);
        chk("R3 flag cleared", los_a[0], 0);
        chk("R3 other input untouched", los_a[1], 1);
        wait_ref(ACT + 10);
        chk("R4 single edge then loss", los_a[0], 1);
    endtask

    task automatic test_run_and_stop_R2_R4();
        half0 = 10.0; run[0] = 1'b1;
        wait_ref(8);
        chk("R2 present with running clock", los_a[0], 0);
        wait_ref(50);
        chk("R2 still present", los_a[0], 0);
        run[0] = 1'b0;
        wait_ref(ACT - 2);
        chk("R4 not yet lost", los_a[0], 0);
        wait_ref(10);
        chk("R4 lost", los_a[0], 1);
    endtask

    task automatic test_independent_R5();
        half0 = 10.0; half1 = 7.0; run = 2'b11;
        wait_ref(20);
        chk("R5 both present", los_a, 0);
        run[0] = 1'b0;
        wait_ref(ACT + 10);
        chk("R5 stopped input lost", los_a[0], 1);
        chk("R5 running input unaffected", los_a[1], 0);
        run[1] = 1'b0;
        wait_ref(ACT + 10);
        chk("R5 second input lost", los_a[1], 1);
    endtask

    task automatic test_slow_R8();
        int seen;
        seen = 0;
        half0 = 80.0; run[0] = 1'b1;
        wait_ref(30);
        for (int k = 0; k < 300; k++) begin
            wait_ref(1);
            if (los_a[0]) seen++;
        end
        chk("R8 slow clock never flagged", seen, 0);
        run[0] = 1'b0;
        wait_ref(ACT + 30);
        chk("R8 slow clock stop lost", los_a[0], 1);
    endtask

    task automatic test_fast_R9();
        half0 = 0.69; run[0] = 1'b1;
        wait_ref(10);
        chk("R9 fast clock present", los_a[0], 0);
        wait_ref(40);
        chk("R9 fast clock stays present", los_a[0], 0);
        run[0] = 1'b0;
        wait_ref(ACT + 10);
        chk("R9 fast clock stop lost", los_a[0], 1);
    endtask

    task automatic test_three_edges_R6();
        pulse_b();
        wait_ref(10);
        chk("R6 one edge keeps absent", los_b[0], 1);
        pulse_b();
        wait_ref(10);
        chk("R6 two edges keep absent", los_b[0], 1);
        pulse_b();
        wait_ref(10);
        chk("R6 third edge clears", los_b[0], 0);
        wait_ref(ACT + 10);
        chk("R6 back to absent", los_b[0], 1);
    endtask

    task automatic test_gap_R7();
        pulse_b();
        wait_ref(10);
        pulse_b();
        wait_ref(ACT + 20);
        pulse_b();
        wait_ref(10);
        chk("R7 earlier edges discarded", los_b[0], 1);
        pulse_b();
        wait_ref(10);
        chk("R7 two fresh edges keep absent", los_b[0], 1);
        pulse_b();
        wait_ref(10);
        chk("R7 three fresh edges clear", los_b[0], 0);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset_R1();
        test_single_edge_R3();
        test_run_and_stop_R2_R4();
        test_independent_R5();
        test_slow_R8();
        test_fast_R9();
        test_three_edges_R6();
        test_gap_R7();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule